// File: doc/BRIEF.md
# Lockable General-Purpose I/O Port

A sixteen-pin I/O port controlled through a small 32-bit register bus. Each pin carries a four-bit setup field. The field selects whether the pin is an input or an output. For an input, it picks analog, floating or pulled behaviour. For an output, it picks push-pull or open-drain, and whether the driven value comes from the port's output data or from an alternate source. From these fields the block drives per-pin pad output-enable, output value and pull-up/pull-down controls. It also exports each pin's two-bit speed code.

The output data can be written whole. It can also be changed bit-wise with no read-modify-write, through a combined set/clear register or a clear-only register. Pad inputs are synchronised before they become readable. A three-write key sequence, completed by a read, freezes the setup fields of chosen pins until the next reset.

The bus uses a word address. A write is `bus_sel & bus_wr`. A read is `bus_sel & !bus_wr`, and read data is returned combinationally in the same cycle. Word addresses: 0 setup-low, 1 setup-high, 2 input data (read-only), 3 output data, 4 set/clear (write-only), 5 clear-only (write-only), 6 lock. Unused addresses read as zero.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset every setup field reads 0x4, output data reads 0, the lock word reads 0, and all pad output-enable and pull outputs are low.
- R2: Pin n's field sits at bits 4*(n mod 8)+3 : 4*(n mod 8). It is in setup-low (address 0) for pins 0..7 and in setup-high (address 1) for pins 8..15. Written fields read back unchanged.
- R3: Field bits [1:0] are the mode: 00 is input, and a non-zero value is output with that speed code, exported on pin_speed[2n+1:2n]. Output with sub-type (bits [3:2]) 00 is push-pull: output-enable is 1 and pad_out equals the output data bit.
- R4: Output with sub-type 01 is open-drain: pad_out is 0 and output-enable is high only when the output data bit is 0.
- R5: Output with sub-type 10 or 11 takes its value from alt_in[n] in place of the output data bit. 10 is push-pull and 11 is open-drain.
- R6: In input mode output-enable is 0. Sub-type 10 (pulled) raises pad_pu when the output data bit is 1 and pad_pd when it is 0. Sub-types 00 and 01 raise neither pull.
- R7: A write to set/clear (address 4) sets output bits written 1 in [15:0] and clears output bits written 1 in [31:16]. When both hit one bit, the set wins.
- R8: A write to clear-only (address 5) clears output bits written 1 in [15:0]. Bits [31:16] have no effect.
- R9: The input data word (address 2) shows pad_in in its low 16 bits two clock edges after pad_in changes.
- R10: Lock word (address 6): bits [15:0] are the pin mask and bit 16 is the key. Writing key 1, then key 0, then key 1, all with the same mask, then reading address 6, locks the masked pins. Later reads return key 1 with that mask. Locked pins' fields ignore writes, and other pins stay writable.
- R11: A write with a different mask, or a key value out of order, returns the sequence to its start, and a later read does not lock.
- R12: Once locked, writes to the lock word are ignored, and the lock and its mask hold until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 16 | Asynchronous pad inputs |
| alt_in | input | 16 | Alternate-source output values |
| pad_oe | output | 16 | Pad output-enable |
| pad_out | output | 16 | Pad output value |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pin_speed | output | 32 | Two-bit speed code per pin |

## Verification
A wrong field or output data bit shows on the pad controls in the cycle after the faulty write, so the mode table is checked one cycle after each setup write. A lock sequence machine that advances wrongly shows only at the next read of the lock word or at the next setup write. For that reason every sequence, whether aborted or complete, is followed by a read of the lock word and a setup write to both locked and free pins. A synchroniser with the wrong depth shows as input data one edge early or late, and is checked at each of those edges.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
    localparam logic [2:0] A_CFG_LO = 3'd0;
    localparam logic [2:0] A_CFG_HI = 3'd1;
    localparam logic [2:0] A_IN     = 3'd2;
    localparam logic [2:0] A_OUT    = 3'd3;
    localparam logic [2:0] A_SETCLR = 3'd4;
    localparam logic [2:0] A_CLR    = 3'd5;
    localparam logic [2:0] A_LOCK   = 3'd6;

    localparam logic [3:0] CFG_RESET = 4'h4;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ONE   = 2'd1,
        LK_ZERO  = 2'd2,
        LK_ARMED = 2'd3
    } lk_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
    input  logic [3:0] cfg,
    input  logic       odr_bit,
    input  logic       alt_bit,
    output logic       oe,
    output logic       out,
    output logic       pu,
    output logic       pd,
    output logic [1:0] speed
);
    logic [1:0] mode, sub;
    logic       src;

    always_comb begin
        mode  = cfg[1:0];
        sub   = cfg[3:2];
        src   = sub[1] ? alt_bit : odr_bit;
        oe    = 1'b0;
        out   = 1'b0;
        pu    = 1'b0;
        pd    = 1'b0;
        speed = mode;
        if (mode != 2'b00) begin
            if (sub[0]) begin
                oe  = ~src;
                out = 1'b0;
            end else begin
                oe  = 1'b1;
                out = src;
            end
        end else if (sub == 2'b10) begin
            pu = odr_bit;
            pd = ~odr_bit;
        end
    end
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
    import gpio_lock_pkg::*;
#(
    parameter int N_PINS = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic              rd_lock,
    input  logic [DATA_W-1:0] wdata,
    output logic              lock_key,
    output logic [N_PINS-1:0] lock_mask
);
    localparam int KEY_BIT = N_PINS;

    typedef struct packed {
        lk_state_e         state;
        logic [N_PINS-1:0] pend;
        logic              locked;
        logic [N_PINS-1:0] mask;
    } lk_regs_t;

    lk_regs_t lk_d, lk_q;
    logic              wkey;
    logic [N_PINS-1:0] wmask;
    logic              same;

    always_comb begin
        wkey  = wdata[KEY_BIT];
        wmask = wdata[N_PINS-1:0];
        same  = (wmask == lk_q.pend);
        lk_d  = lk_q;
        if (!lk_q.locked) begin
            if (wr_lock) begin
                unique case (lk_q.state)
                    LK_IDLE: begin
                        lk_d.state = wkey ? LK_ONE : LK_IDLE;
                        lk_d.pend  = wmask;
                    end
                    LK_ONE:  lk_d.state = (!wkey && same) ? LK_ZERO  : LK_IDLE;
                    LK_ZERO: lk_d.state = ( wkey && same) ? LK_ARMED : LK_IDLE;
                    default: lk_d.state = LK_IDLE;
                endcase
            end else if (rd_lock && lk_q.state == LK_ARMED) begin
                lk_d.locked = 1'b1;
                lk_d.mask   = lk_q.pend;
                lk_d.state  = LK_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{state: LK_IDLE, pend: '0, locked: 1'b0, mask: '0};
        else        lk_q <= lk_d;
    end

    assign lock_key  = lk_q.locked;
    assign lock_mask = lk_q.mask;
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
    import gpio_lock_pkg::*;
#(
    parameter int N_PINS  = 16,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int ADDR_W  = 3,
    parameter int SYNC_N  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_PINS-1:0]   pad_in,
    input  logic [N_PINS-1:0]   alt_in,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_PINS-1:0]   pad_out,
    output logic [N_PINS-1:0]   pad_pu,
    output logic [N_PINS-1:0]   pad_pd,
    output logic [2*N_PINS-1:0] pin_speed
);
    localparam int PER_REG = DATA_W / FIELD_W;

    typedef struct packed {
        logic [N_PINS-1:0][FIELD_W-1:0] cfg;
        logic [N_PINS-1:0]              odr;
    } port_regs_t;

    port_regs_t        r_d, r_q;
    logic              wr_en, rd_en;
    logic              lock_key;
    logic [N_PINS-1:0] lock_mask;
    logic [N_PINS-1:0] idr;
    logic [N_PINS-1:0] odr_q;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;
    assign odr_q = r_q.odr;

    gpio_lock_seq #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lock  (wr_en && bus_addr == A_LOCK),
        .rd_lock  (rd_en && bus_addr == A_LOCK),
        .wdata    (bus_wdata),
        .lock_key (lock_key),
        .lock_mask(lock_mask)
    );

    gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(idr)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (bus_addr)
                A_CFG_LO: for (int p = 0; p < PER_REG; p++)
                    if (!lock_mask[p]) r_d.cfg[p] = bus_wdata[FIELD_W*p +: FIELD_W];
                A_CFG_HI: for (int p = 0; p < PER_REG; p++)
                    if (!lock_mask[p+PER_REG]) r_d.cfg[p+PER_REG] = bus_wdata[FIELD_W*p +: FIELD_W];
                A_OUT:    r_d.odr = bus_wdata[N_PINS-1:0];
                A_SETCLR: r_d.odr = (r_q.odr & ~bus_wdata[2*N_PINS-1:N_PINS]) | bus_wdata[N_PINS-1:0];
                A_CLR:    r_d.odr = r_q.odr & ~bus_wdata[N_PINS-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg <= {N_PINS{CFG_RESET}};
            r_q.odr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG_LO: for (int p = 0; p < PER_REG; p++) bus_rdata[FIELD_W*p +: FIELD_W] = r_q.cfg[p];
            A_CFG_HI: for (int p = 0; p < PER_REG; p++) bus_rdata[FIELD_W*p +: FIELD_W] = r_q.cfg[p+PER_REG];
            A_IN:     bus_rdata[N_PINS-1:0] = idr;
            A_OUT:    bus_rdata[N_PINS-1:0] = r_q.odr;
            A_LOCK:   bus_rdata[N_PINS:0]   = {lock_key, lock_mask};
            default:  bus_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_pin_drive u_drv (
            .cfg    (r_q.cfg[g]),
            .odr_bit(r_q.odr[g]),
            .alt_bit(alt_in[g]),
            .oe     (pad_oe[g]),
            .out    (pad_out[g]),
            .pu     (pad_pu[g]),
            .pd     (pad_pd[g]),
            .speed  (pin_speed[2*g +: 2])
        );
    end
endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk #(
    parameter int N_PINS = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N_PINS-1:0] pad_in,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_pu,
    input logic [N_PINS-1:0] pad_pd,
    input logic              lock_key,
    input logic [N_PINS-1:0] lock_mask,
    input logic [N_PINS-1:0] odr_q,
    input logic [N_PINS-1:0] idr
);
    logic [1:0] age_q;
    logic       setclr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign setclr_wr = bus_sel && bus_wr && bus_addr == 3'd4;

    // R12
    key_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_key |=> lock_key);

    // R12
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_key |=> $stable(lock_mask));

    // R6
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R4
    no_undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> idr == $past(pad_in, 2));

    // R7
    setclr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setclr_wr |=> odr_q == (($past(odr_q) & ~$past(bus_wdata[2*N_PINS-1:N_PINS]))
                                | $past(bus_wdata[N_PINS-1:0])));
endmodule

bind gpio_lock_port gpio_lock_port_chk #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .lock_key (lock_key),
    .lock_mask(lock_mask),
    .odr_q    (odr_q),
    .idr      (idr)
);

// File: tb/sim_gpio_lock_port.sv
module sim_gpio_lock_port;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [3:0] cfg;
        logic       odr;
        logic       alt;
        logic       oe;
        logic       out;
        logic       pu;
        logic       pd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'h4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'h8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'h2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'h9, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] alt_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pu, pad_pd;
    logic [31:0] pin_speed;

    int errors = 0;
    int checks = 0;
    logic [31:0] rd;

    gpio_lock_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .alt_in(alt_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pin_speed(pin_speed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        bus_read(3'd0, rd); check("R1 cfg_lo", rd, 32'h44444444);
        bus_read(3'd1, rd); check("R1 cfg_hi", rd, 32'h44444444);
        bus_read(3'd3, rd); check("R1 odr", rd, 32'h0);
        bus_read(3'd6, rd); check("R1 lock", rd, 32'h0);
        @(negedge clk);
        check("R1 pads", {pad_oe, pad_pu | pad_pd}, 32'h0);

        // R3 R4 R5 R6 mode table on pin 0
        foreach (VECS[i]) begin
            bus_write(3'd0, 32'h44444440 | {28'h0, VECS[i].cfg});
            bus_write(3'd3, {31'h0, VECS[i].odr});
            @(negedge clk);
            alt_in = {15'h0, VECS[i].alt};
            #1;
            check($sformatf("R3 R4 R5 R6 row %0d", i),
                  {28'h0, pad_oe[0], pad_out[0], pad_pu[0], pad_pd[0]},
                  {28'h0, VECS[i].oe, VECS[i].out, VECS[i].pu, VECS[i].pd});
        end
        alt_in = '0;

        // R2 field layout in the high register, R3 speed export
        bus_write(3'd1, 32'h12345678);
        bus_read(3'd1, rd); check("R2 cfg_hi readback", rd, 32'h12345678);
        bus_read(3'd0, rd); check("R2 cfg_lo untouched", rd, 32'h4444444F);
        check("R3 speed pin9", {30'h0, pin_speed[19:18]}, 32'd3);
        check("R3 pin15 pushpull oe", {31'h0, pad_oe[15]}, 32'd1);

        // R7 set/clear with set priority on bit 8
        bus_write(3'd3, 32'h000000F0);
        bus_write(3'd4, 32'h0F300301);
        bus_read(3'd3, rd); check("R7 setclr", rd, 32'h000003C1);
        // R8 clear-only, upper half ignored
        bus_write(3'd5, 32'hFFFF0041);
        bus_read(3'd3, rd); check("R8 clr", rd, 32'h00000380);

        // R9 two-edge synchroniser
        @(negedge clk); pad_in = 16'hA5C3;
        @(negedge clk);
        bus_addr = 3'd2; #1; check("R9 after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1; check("R9 after two edges", bus_rdata, 32'h0000A5C3);

        // R11 aborted sequences
        do_reset();
        bus_write(3'd6, 32'h00010003);
        bus_write(3'd6, 32'h00000005);
        bus_write(3'd6, 32'h00010003);
        bus_read(3'd6, rd);
        bus_read(3'd6, rd); check("R11 mask mismatch", rd, 32'h0);
        bus_write(3'd6, 32'h00000003);
        bus_write(3'd6, 32'h00010003);
        bus_write(3'd6, 32'h00010003);
        bus_read(3'd6, rd);
        bus_read(3'd6, rd); check("R11 out of order", rd, 32'h0);
        bus_write(3'd0, 32'h11111111);
        bus_read(3'd0, rd); check("R11 no freeze", rd, 32'h11111111);

        // R10 full sequence
        bus_write(3'd0, 32'h44444444);
        bus_write(3'd6, 32'h00010003);
        bus_write(3'd6, 32'h00000003);
        bus_write(3'd6, 32'h00010003);
        bus_read(3'd6, rd);
        bus_read(3'd6, rd); check("R10 key readback", rd, 32'h00010003);
        bus_write(3'd0, 32'h11111111);
        bus_read(3'd0, rd); check("R10 locked pins frozen", rd, 32'h11111144);

        // R12 lock writes ignored after locking
        bus_write(3'd6, 32'h00000000);
        bus_write(3'd6, 32'h0001FFFF);
        bus_read(3'd6, rd); check("R12 lock word held", rd, 32'h00010003);
        bus_write(3'd0, 32'h22222222);
        bus_read(3'd0, rd); check("R12 still frozen", rd, 32'h22222244);
        do_reset();
        bus_read(3'd6, rd); check("R12 cleared by reset", rd, 32'h0);
        bus_write(3'd0, 32'h22222222);
        bus_read(3'd0, rd); check("R12 writable after reset", rd, 32'h22222222);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule